// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block gives a single hart a free-running 64-bit time base and a 64-bit compare value. A prescaler divides the core clock by a fixed ratio (16 by default), so the time counter advances once per prescaler period. A machine-timer interrupt line is raised once the time counter has reached or passed the compare value. The line stays raised until software writes either half of the compare value.

Software uses a 32-bit synchronous register bus. A request is presented for one cycle with valid, write, a byte address and write data. Read data and an acknowledge come back, both registered, on the following cycle. Each 64-bit quantity appears as a low word and a high word. Reading the high time word does not capture the low word. Software that needs a consistent 64-bit time must read high, low, high and repeat the sequence if the high word changed.

Top module: `mtimer_top`

## Requirements
- R1: After reset is released, the time counter increases by exactly one on every DIV-th rising clock edge (DIV = 16 by default). The first increment happens on the 16th edge with reset low, so after k such edges the time equals floor(k/16).
- R2: A read at byte offset 0xBFF8 returns time bits 31:0. A read at 0xBFFC returns time bits 63:32.
- R3: The compare value is readable and writable at offset 0x4000 (bits 31:0) and at offset 0x4004 (bits 63:32). A write changes only the half it addresses.
- R4: A write to either compare offset forces the interrupt output low on the following clock edge. This takes priority over a set condition in the same cycle.
- R5: When the registered time is greater than or equal to the registered compare value (unsigned), the interrupt output is high after the next clock edge, unless R4 applies.
- R6: Once high, the interrupt output stays high until a compare write clears it.
- R7: Reset (synchronous, active high) makes the time and prescaler zero, the interrupt output low and the compare value all ones.
- R8: A read returns its data one cycle after the request, with the acknowledge high for exactly that cycle. The data reflects the state at the capturing edge. Reads of any other offset, or of an address whose two low bits are not zero, return zero.
- R9: Writes to the time offsets, or to any offset other than the two compare offsets, change neither the time nor the compare value, and they do not clear the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ack | output | 1 | High in the cycle the read or write response is returned |
| timer_irq | output | 1 | Machine-timer-pending interrupt |

## Verification
The colliding pair is a compare write and the time counter reaching the compare value, both on the same edge. The bench arms a compare value one tick ahead of the current time. It then rewrites the same value after a delay that it sweeps across more than a full prescaler period, so that one delay lands exactly on the crossing edge. A bench model, derived from R4 to R6, predicts the interrupt level on every cycle. In the colliding cycle the write must win, and the interrupt must reappear one edge later.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 16'h4000;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 16'h4004;
  localparam logic [ADDR_W-1:0] OFS_TIME_LO = 16'hBFF8;
  localparam logic [ADDR_W-1:0] OFS_TIME_HI = 16'hBFFC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_CMP_LO,
    SEL_CMP_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_TIME_LO: s = SEL_TIME_LO;
      OFS_TIME_HI: s = SEL_TIME_HI;
      OFS_CMP_LO:  s = SEL_CMP_LO;
      OFS_CMP_HI:  s = SEL_CMP_HI;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [TW-1:0] time_q
);
  always_ff @(posedge clk) begin
    if (rst)       time_q <= '0;
    else if (tick) time_q <= time_q + 1'b1;
  end
endmodule

// File: rtl/mtimer_regs.sv
module mtimer_regs
  import mtimer_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [TW-1:0]     time_val,
  output logic [TW-1:0]     cmp_q,
  output logic              cmp_wr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ack
);
  localparam int HALVES = TW / WORD_W;

  reg_sel_e sel;
  logic     wr_en, rd_en;

  assign sel    = decode_sel(bus_addr);
  assign wr_en  = bus_valid && bus_write;
  assign rd_en  = bus_valid && !bus_write;
  assign cmp_wr = wr_en && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);

  for (genvar h = 0; h < HALVES; h++) begin : g_cmp
    localparam reg_sel_e MY_SEL = (h == 0) ? SEL_CMP_LO : SEL_CMP_HI;
    always_ff @(posedge clk) begin
      if (rst)
        cmp_q[h*WORD_W +: WORD_W] <= '1;
      else if (wr_en && sel == MY_SEL)
        cmp_q[h*WORD_W +: WORD_W] <= bus_wdata;
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_TIME_LO: rd_mux = time_val[WORD_W-1:0];
      SEL_TIME_HI: rd_mux = time_val[TW-1:WORD_W];
      SEL_CMP_LO:  rd_mux = cmp_q[WORD_W-1:0];
      SEL_CMP_HI:  rd_mux = cmp_q[TW-1:WORD_W];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
    end else begin
      bus_rdata <= rd_en ? rd_mux : '0;
      bus_ack   <= bus_valid;
    end
  end
endmodule

// File: rtl/mtimer_pending.sv
module mtimer_pending #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_val,
  input  logic [TW-1:0] cmp_val,
  input  logic          cmp_wr,
  output logic          pend_q
);
  logic due;
  assign due = (time_val >= cmp_val);

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (cmp_wr) pend_q <= 1'b0;
    else if (due)    pend_q <= 1'b1;
  end
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int DIV = 16,
  parameter int TW  = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [15:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic        timer_irq
);
  logic          tick;
  logic [TW-1:0] time_q;
  logic [TW-1:0] cmp_q;
  logic          cmp_wr;

  mtimer_prescale #(.DIV(DIV)) u_pre (
    .clk (clk), .rst (rst), .tick (tick)
  );

  mtimer_counter #(.TW(TW)) u_cnt (
    .clk (clk), .rst (rst), .tick (tick), .time_q (time_q)
  );

  mtimer_regs #(.TW(TW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .time_val  (time_q),
    .cmp_q     (cmp_q),
    .cmp_wr    (cmp_wr),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

  mtimer_pending #(.TW(TW)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .time_val (time_q),
    .cmp_val  (cmp_q),
    .cmp_wr   (cmp_wr),
    .pend_q   (timer_irq)
  );
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [15:0]   bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          bus_ack,
  input logic          timer_irq,
  input logic [TW-1:0] time_val,
  input logic [TW-1:0] cmp_val
);
  logic is_cmp, is_map;
  assign is_cmp = (bus_addr == 16'h4000) || (bus_addr == 16'h4004);
  assign is_map = is_cmp || (bus_addr == 16'hBFF8) || (bus_addr == 16'hBFFC);

  assert_reset_vals_R7: assert property (@(posedge clk)
    rst |=> (time_val == '0) && !timer_irq && (cmp_val == '1));

  assert_time_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (time_val == $past(time_val)) || (time_val == $past(time_val) + 1'b1));

  assert_cmp_wr_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && is_cmp) |=> !timer_irq);

  assert_due_sets_R5: assert property (@(posedge clk) disable iff (rst)
    ((time_val >= cmp_val) && !(bus_valid && bus_write && is_cmp)) |=> timer_irq);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (timer_irq && !(bus_valid && bus_write && is_cmp)) |=> timer_irq);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !is_map) |=> (bus_ack && bus_rdata == '0));

  assert_other_wr_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !is_cmp) |=> $stable(cmp_val));
endmodule

bind mtimer_top mtimer_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_ack   (bus_ack),
  .timer_irq (timer_irq),
  .time_val  (time_q),
  .cmp_val   (cmp_q)
);

// File: tb/mtimer_top_tb.sv
module mtimer_top_tb;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        timer_irq;

  int checks = 0;
  int errors = 0;
  bit monitor_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mtimer_top u_dut (
    .clk (clk), .rst (rst),
    .bus_valid (bus_valid), .bus_write (bus_write),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_ack (bus_ack),
    .timer_irq (timer_irq)
  );

  // Reference model built from the requirements
  longint      m_edges;
  logic [63:0] m_cmp;
  logic        m_pend;
  logic [31:0] m_rd;
  logic        m_ack;

  function automatic logic [63:0] m_time();
    return 64'(m_edges / DIV);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_edges = 0; m_cmp = '1; m_pend = 1'b0; m_rd = '0; m_ack = 1'b0;
    end else begin
      logic [63:0] t;
      logic cw;
      t  = m_time();
      cw = bus_valid && bus_write && (bus_addr == 16'h4000 || bus_addr == 16'h4004);
      m_ack = bus_valid;
      m_rd  = '0;
      if (bus_valid && !bus_write) begin
        case (bus_addr)
          16'hBFF8: m_rd = t[31:0];
          16'hBFFC: m_rd = t[63:32];
          16'h4000: m_rd = m_cmp[31:0];
          16'h4004: m_rd = m_cmp[63:32];
          default:  m_rd = '0;
        endcase
      end
      if (cw) m_pend = 1'b0;
      else if (t >= m_cmp) m_pend = 1'b1;
      if (bus_valid && bus_write && bus_addr == 16'h4000) m_cmp[31:0]  = bus_wdata;
      if (bus_valid && bus_write && bus_addr == 16'h4004) m_cmp[63:32] = bus_wdata;
      m_edges = m_edges + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (monitor_on && !rst) begin
      check("R4/R5/R6 irq", {63'd0, timer_irq}, {63'd0, m_pend});
      check("R8 ack", {63'd0, bus_ack}, {63'd0, m_ack});
      if (m_ack) check("R2/R3/R8 rdata", {32'd0, bus_rdata}, {32'd0, m_rd});
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] t0;
    idle(3);
    check("R7 irq in reset", {63'd0, timer_irq}, 64'd0);
    @(negedge clk) rst = 1'b0;
    monitor_on = 1'b1;

    // R7: reset values
    rd(16'h4000, v);  check("R7 cmp lo reset", {32'd0, v}, 64'hFFFF_FFFF);
    rd(16'h4004, v);  check("R7 cmp hi reset", {32'd0, v}, 64'hFFFF_FFFF);
    rd(16'hBFF8, v);  check("R7 time lo near zero", {32'd0, v}, 64'd0);
    check("R7 irq low", {63'd0, timer_irq}, 64'd0);

    // R1: rate, explicit arithmetic from edge count
    idle(200);
    rd(16'hBFF8, v);  check("R1 time after 206 edges", {32'd0, v}, 64'd12);
    rd(16'hBFFC, v);  check("R2 time hi", {32'd0, v}, 64'd0);
    rd(16'hBFF8, v);
    idle(DIV - 1);
    rd(16'hBFF8, v2); check("R1 one step per DIV", {32'd0, v2 - v}, 64'd1);

    // R3: half independence
    wr(16'h4000, 32'h1234_5678);
    rd(16'h4004, v);  check("R3 hi untouched", {32'd0, v}, 64'hFFFF_FFFF);
    rd(16'h4000, v);  check("R3 lo written", {32'd0, v}, 64'h1234_5678);
    wr(16'h4004, 32'hDEAD_0001);
    rd(16'h4000, v);  check("R3 lo untouched", {32'd0, v}, 64'h1234_5678);
    wr(16'h4004, 32'hFFFF_FFFF);

    // R8: unmapped and misaligned reads
    rd(16'h0000, v);  check("R8 unmapped 0000", {32'd0, v}, 64'd0);
    rd(16'h4008, v);  check("R8 unmapped 4008", {32'd0, v}, 64'd0);
    rd(16'hBFF4, v);  check("R8 unmapped BFF4", {32'd0, v}, 64'd0);
    rd(16'h4001, v);  check("R8 misaligned 4001", {32'd0, v}, 64'd0);

    // R9: writes elsewhere have no effect
    wr(16'hBFF8, 32'h0000_5555);
    wr(16'h4008, 32'h0);
    wr(16'h4003, 32'h0);
    rd(16'h4000, v);  check("R9 cmp lo kept", {32'd0, v}, 64'h1234_5678);
    rd(16'hBFF8, v);  check("R9 time unaffected", {32'd0, v}, {32'd0, m_time()});

    // R5/R6: sweep compare distance, per-cycle model comparison
    for (int d = 0; d < 8; d++) begin
      wr(16'h4004, 32'h0);
      t0 = m_time();
      wr(16'h4000, t0[31:0] + 32'(d));
      idle(DIV * (d + 2));
      check("R5 irq after due", {63'd0, timer_irq}, 64'd1);
      idle(DIV);
      check("R6 irq held", {63'd0, timer_irq}, 64'd1);
      wr(16'hBFF8, 32'h0);
      check("R9 time write keeps irq", {63'd0, timer_irq}, 64'd1);
      wr(16'h4004, 32'hFFFF_FFFF);
      check("R4 cleared by cmp write", {63'd0, timer_irq}, 64'd0);
    end

    // R4 versus R5 collision sweep: rewrite compare across the crossing edge
    for (int p = 0; p < DIV + 6; p++) begin
      wr(16'h4004, 32'h0);
      t0 = m_time();
      wr(16'h4000, t0[31:0] + 32'd1);
      idle(p);
      wr(16'h4000, t0[31:0] + 32'd1);
      idle(DIV + 4);
      check("R5 irq re-set after collision", {63'd0, timer_irq}, 64'd1);
      wr(16'h4004, 32'hFFFF_FFFF);
    end

    // Same-value rewrite while pending: clears then sets again one edge later
    wr(16'h4004, 32'h0);
    wr(16'h4000, 32'h0);
    idle(2);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'h4000; bus_wdata = 32'h0;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R4 write clears at next edge", {63'd0, timer_irq}, 64'd0);
    @(negedge clk);
    check("R5 reasserts one edge later", {63'd0, timer_irq}, 64'd1);

    idle(4);
    monitor_on = 1'b0;
    finish_run();
  end
endmodule